// File: doc/BRIEF.md
# Closed-Loop Bulk Erase Sequencer

This controller sits on the host side of a byte-wide reprogrammable memory and drives the complete whole-array erase loop over the memory's command interface. A start request raises the high-voltage enable. The controller then writes the two-byte erase command and holds off the bus for the length of one erase pulse. After the pulse it walks the address space with erase-verify accesses. Each access is a verify command write carrying the address, followed by a read. Every byte must read back as all ones. The array is not preprogrammed before erasing.

When a byte reads back with any zero bit, the controller keeps that address. It issues another erase pulse and then picks up verification at the kept address instead of at zero. The number of pulses is capped by a budget. At the end, whether the run passed or failed, the controller writes the read command, drops the high-voltage enable and pulses `done`. The error flag and the count of pulses used stay visible until the next start.

Bus cycles are abstracted to a valid/acknowledge handshake. The acknowledge of a read carries the read data. The pulse length is given as a clock-cycle count, so simulation can shorten it.

Top module: `erase_seq`

## Requirements
- R1: After reset `busy`, `done`, `error`, `vpp_en` and `cmd_valid` are low and `pulses` is zero.
- R2: A `start` seen while idle raises `vpp_en` and begins with two writes of 20h. A `start` seen while busy has no effect on the run.
- R3: The only bytes ever written are 20h (erase), A0h (erase verify) and 00h (read). No programming write precedes the erase.
- R4: After the acknowledge of the second 20h write, `cmd_valid` stays low for exactly PULSE_CYCLES cycles before the next command.
- R5: Verification starts at address 0. For each address it performs a write of A0h carrying that address, then a read of the same address. Data of FFh passes, and the address advances by one up to the last address (all ones).
- R6: When a verify read returns anything other than FFh, the controller issues a new erase pulse. The first verify after that pulse uses the failing address.
- R7: `pulses` counts the erase pulses issued in the current run and never exceeds MAX_PULSES. A run whose final pass succeeds on exactly pulse MAX_PULSES ends without error.
- R8: If a verify read fails after pulse MAX_PULSES has been issued, the run ends with `error` high.
- R9: Every run ends with a write of 00h. `vpp_en` then falls in the same cycle as a one-cycle `done` pulse, and `busy` falls with it. `error` holds its value until the next start.
- R10: While `cmd_valid` is high and not yet acknowledged, `cmd_write`, `cmd_addr` and `cmd_data` stay stable. `cmd_valid` is high only while `vpp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run one erase loop |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | Last run exhausted the pulse budget |
| pulses | output | CNT_W | Erase pulses issued in the current or last run |
| vpp_en | output | 1 | High-voltage enable for the memory |
| cmd_valid | output | 1 | Bus access requested |
| cmd_write | output | 1 | 1 for a command write, 0 for a read |
| cmd_addr | output | ADDR_W | Address of the access |
| cmd_data | output | DATA_W | Command byte for writes |
| cmd_ack | input | 1 | One-cycle acknowledge completing the access |
| rd_data | input | DATA_W | Read data, valid with the acknowledge of a read |

## Verification
The bench runs the loop against a memory model in which each address needs a chosen number of erase pulses. The patterns are: every byte clearing on the first pulse, two stubborn bytes at different addresses, a byte that clears only on the last allowed pulse, and a byte that never clears. The single-pulse case shows the plain walk and the pulse timing. The two-stubborn-byte case shows that verification resumes at the kept address and does not restart at zero. The last-pulse case and the never-clears case sit on either side of the budget boundary, separating success from error. A second start during a run shows that the request is ignored while busy.

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 5_000_000,
  parameter int MAX_PULSES   = 30,
  parameter int CNT_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [CNT_W-1:0]  pulses,
  output logic              vpp_en,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ack,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int TMR_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] OP_ERASE  = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0] OP_VERIFY = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] OP_READ   = DATA_W'(8'h00);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ERASE, S_WAIT, S_VCMD, S_VRD, S_EXIT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [TMR_W-1:0]  tmr;
  logic              fail_q;

  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st != S_IDLE) && (st != S_WAIT);
  assign cmd_write = (st != S_VRD);
  assign cmd_addr  = (st == S_VCMD || st == S_VRD) ? addr : '0;

  always_comb begin
    case (st)
      S_SETUP, S_ERASE: cmd_data = OP_ERASE;
      S_VCMD:           cmd_data = OP_VERIFY;
      default:          cmd_data = OP_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      tmr    <= '0;
      fail_q <= 1'b0;
      pulses <= '0;
      error  <= 1'b0;
      done   <= 1'b0;
      vpp_en <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SETUP;
          vpp_en <= 1'b1;
          addr   <= '0;
          pulses <= '0;
          error  <= 1'b0;
          fail_q <= 1'b0;
        end
        S_SETUP: if (cmd_ack) st <= S_ERASE;
        S_ERASE: if (cmd_ack) begin
          pulses <= pulses + 1'b1;
          tmr    <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr == TMR_W'(PULSE_CYCLES - 1)) st <= S_VCMD;
          else tmr <= tmr + 1'b1;
        end
        S_VCMD: if (cmd_ack) st <= S_VRD;
        S_VRD: if (cmd_ack) begin
          if (&rd_data) begin
            if (addr == LAST_ADDR) st <= S_EXIT;
            else begin
              addr <= addr + 1'b1;
              st   <= S_VCMD;
            end
          end else if (pulses == CNT_W'(MAX_PULSES)) begin
            fail_q <= 1'b1;
            st     <= S_EXIT;
          end else begin
            st <= S_SETUP;
          end
        end
        S_EXIT: if (cmd_ack) begin
          st     <= S_IDLE;
          vpp_en <= 1'b0;
          done   <= 1'b1;
          error  <= fail_q;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module erase_seq_chk #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 30,
  parameter int CNT_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [CNT_W-1:0]  pulses,
  input logic              vpp_en,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              cmd_ack
);
  a_r10_valid_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> vpp_en);
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_data)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !vpp_en));
  a_r9_error_changes_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);
  a_r7_budget: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= CNT_W'(MAX_PULSES));
  a_r3_legal_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> (cmd_data == 8'h20 || cmd_data == 8'hA0 || cmd_data == 8'h00));
endmodule

bind erase_seq erase_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error), .pulses(pulses),
  .vpp_en(vpp_en), .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .cmd_ack(cmd_ack));

// File: tb/tb_erase_seq.sv
module tb_erase_seq;
  localparam int AW = 4;
  localparam int PC = 20;
  localparam int MP = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, error, vpp_en, cmd_valid, cmd_write;
  logic [4:0] pulses;
  logic [AW-1:0] cmd_addr;
  logic [7:0] cmd_data;
  logic cmd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;

  always #10 clk = ~clk;

  erase_seq #(.ADDR_W(AW), .DATA_W(8), .PULSE_CYCLES(PC), .MAX_PULSES(MP), .CNT_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
    .pulses(pulses), .vpp_en(vpp_en), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ack(cmd_ack), .rd_data(rd_data));

  int checks = 0, errors = 0, cyc = 0;
  int need [16];
  logic clr = 1'b0;
  int n_erase, n20, n_reads, bad_cmd, bad_seq, idle_busy, done_cnt, first_vfy;
  int resume [32];
  logic pend20, after_erase, seen_any;
  logic [AW-1:0] prev_vfy;
  logic [7:0] last_w;
  logic first_two_ok;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      n_erase <= 0; n20 <= 0; n_reads <= 0; bad_cmd <= 0; bad_seq <= 0;
      idle_busy <= 0; done_cnt <= 0; first_vfy <= -1; pend20 <= 1'b0;
      after_erase <= 1'b0; seen_any <= 1'b0; prev_vfy <= '0; last_w <= 8'hxx;
      first_two_ok <= 1'b1; cmd_ack <= 1'b0;
      for (int i = 0; i < 32; i++) resume[i] <= -1;
    end else begin
      if (busy && !cmd_valid) idle_busy <= idle_busy + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (cmd_valid && !cmd_ack) begin
        cmd_ack <= 1'b1;
        if (cmd_write) begin
          last_w <= cmd_data;
          if (!seen_any && (cmd_data != 8'h20 || !vpp_en)) first_two_ok <= 1'b0;
          seen_any <= 1'b1;
          if (cmd_data == 8'h20) begin
            n20 <= n20 + 1;
            if (pend20) begin
              n_erase <= n_erase + 1; pend20 <= 1'b0; after_erase <= 1'b1;
            end else pend20 <= 1'b1;
          end else if (cmd_data == 8'hA0) begin
            pend20 <= 1'b0;
            if (after_erase) begin
              if (n_erase < 32) resume[n_erase-1] <= int'(cmd_addr);
              if (first_vfy < 0) first_vfy <= int'(cmd_addr);
              after_erase <= 1'b0;
            end else if (cmd_addr != prev_vfy + 1'b1) bad_seq <= bad_seq + 1;
            prev_vfy <= cmd_addr;
          end else if (cmd_data != 8'h00) bad_cmd <= bad_cmd + 1;
        end else begin
          n_reads <= n_reads + 1;
          if (cmd_addr != prev_vfy) bad_seq <= bad_seq + 1;
          rd_data <= (n_erase >= need[cmd_addr]) ? 8'hFF : 8'h00;
        end
      end else cmd_ack <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic run(input int stray_start_at);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk_eq("R2 busy after start", int'(busy), 1);
    chk_eq("R9 error cleared by start", int'(error), 0);
    for (int k = 0; k < 40000 && !done; k++) begin
      if (k == stray_start_at) start = 1'b1; else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic common_end(input string name, input int exp_p, input int exp_err);
    chk_eq({name, " R9 done seen"}, int'(done), 1);
    chk_eq({name, " R9 busy low"}, int'(busy), 0);
    chk_eq({name, " R9 vpp low"}, int'(vpp_en), 0);
    chk_eq({name, " R9 last write 00h"}, int'(last_w), 0);
    chk_eq({name, " R7 pulses"}, int'(pulses), exp_p);
    chk_eq({name, " R8 error"}, int'(error), exp_err);
    chk_eq({name, " R3 other bytes"}, bad_cmd, 0);
    chk_eq({name, " R2 first write 20h with vpp"}, int'(first_two_ok), 1);
    chk_eq({name, " R4 idle cycles"}, idle_busy, exp_p * PC);
    chk_eq({name, " R5 address order"}, bad_seq, 0);
    chk_eq({name, " R5 first verify at 0"}, first_vfy, 0);
    chk_eq({name, " R2 erase pairs"}, n20, 2 * exp_p);
    @(negedge clk);
    chk_eq({name, " R9 done one cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk_eq("R1 busy", int'(busy), 0);
    chk_eq("R1 done", int'(done), 0);
    chk_eq("R1 error", int'(error), 0);
    chk_eq("R1 vpp", int'(vpp_en), 0);
    chk_eq("R1 valid", int'(cmd_valid), 0);
    chk_eq("R1 pulses", int'(pulses), 0);
  endtask

  task automatic t_single();
    for (int i = 0; i < 16; i++) need[i] = 1;
    run(-1);
    common_end("single", 1, 0);
    chk_eq("R5 reads in one pass", n_reads, 16);
  endtask

  task automatic t_resume();
    for (int i = 0; i < 16; i++) need[i] = 1;
    need[5] = 2; need[11] = 3;
    run(50);
    common_end("resume", 3, 0);
    chk_eq("R6 resume after pulse 2", resume[1], 5);
    chk_eq("R6 resume after pulse 3", resume[2], 11);
    chk_eq("R6 total reads", n_reads, 18);
    chk_eq("R2 stray start single done", done_cnt, 1);
  endtask

  task automatic t_last_pulse();
    for (int i = 0; i < 16; i++) need[i] = 1;
    need[0] = MP;
    run(-1);
    common_end("edge", MP, 0);
    chk_eq("R7 reads", n_reads, MP + 15);
  endtask

  task automatic t_never();
    for (int i = 0; i < 16; i++) need[i] = 1;
    need[3] = 99;
    run(-1);
    common_end("never", MP, 1);
    repeat (5) @(negedge clk);
    chk_eq("R9 error held", int'(error), 1);
    chk_eq("R8 pulses held", int'(pulses), MP);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_resume();
    t_last_pulse();
    t_never();
    t_single();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule